// File: doc/BRIEF.md
# SPI Flash Command Buffer Master

This block sends a single write-type SPI flash transaction, such as an erase or a byte program, from a small byte buffer held on the host side. The buffer holds the opcode in byte 0, then a 24-bit address and any data bytes. Software fills the buffer one byte at a time, writes a byte-count register and pulses `start`. The engine pulls the active-low chip select low. It then clocks the buffer out on `spi_mosi` in SPI mode 0: byte 0 goes first and each byte goes most significant bit first. After the last bit it releases chip select and pulses `done`.

Each transfer is set only by the byte count and the buffer contents. An erase is an opcode followed by three address bytes, which is a count of 4 and 32 clocks. A byte program adds one data byte, which is a count of 5 and 40 clocks. The engine never samples `spi_miso`. The serial clock runs at the system clock divided by `2*HALF`.

Top module: `spi_cmd_master`

## Requirements
- R1: After reset, `spi_cs_n` is 1, `spi_sclk` is 0, `busy` is 0 and `done` is 0.
- R2: The erase opcodes are sector 0x20, 32K block 0x52 and 64K block 0xD8, each in buffer byte 0 with the address in bytes 1 to 3. With a count of 4, exactly 32 rising clock edges occur. Byte 0 is sent first and every byte is sent MSB first.
- R3: A byte program is opcode 0x02, three address bytes and one data byte. With a count of 5 it produces exactly 40 rising edges carrying those bytes in that order.
- R4: `spi_sclk` is low whenever the engine is idle. `spi_mosi` only changes while `spi_sclk` is low, so it is stable from each rising edge until the following falling edge.
- R5: One serial clock period is `2*HALF` system clocks. Chip select is low for at least `HALF` system clocks before the first rising edge, and stays low for at least `HALF` system clocks after the last falling edge.
- R6: `busy` rises in the cycle after an accepted `start`. In the cycle where `spi_cs_n` returns high, `busy` falls and `done` is high for exactly one cycle.
- R7: While `busy` is 1, the engine ignores `start`, buffer byte writes and byte-count writes. The stream in progress and the next transfer both use the values loaded before the transfer began.
- R8: A `start` with a byte count of 0 produces no chip select activity and raises `done` in the following cycle.
- R9: `spi_miso` has no effect on any output.
- R10: A byte count from 1 to 8 sends 8 times that many bits. A count above 8 is treated as 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| buf_we | input | 1 | Write one buffer byte |
| buf_idx | input | 3 | Buffer byte index (0 is sent first) |
| buf_wdata | input | 8 | Byte to write |
| len_we | input | 1 | Write the byte count |
| len_wdata | input | 4 | Byte count (0 to 15) |
| start | input | 1 | Begin a transfer when idle |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_sclk | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in, never sampled |

## Verification
The assertions assume that `start`, the buffer writes and the count writes are synchronous to `clk` and are driven away from its rising edge. They also assume that software only expects its writes to land while `busy` is low. The stimulus drives every input on the falling edge of `clk` and holds `start` for exactly one cycle. It issues writes during a transfer only in the scenario that checks they are dropped. `spi_miso` toggles pseudo-randomly for the whole run, which shows that no stream depends on it.

// File: rtl/spi_cmd_master.sv
module spi_cmd_master #(
  parameter int HALF  = 2,
  parameter int BYTES = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       buf_we,
  input  logic [$clog2(BYTES)-1:0]   buf_idx,
  input  logic [7:0]                 buf_wdata,
  input  logic                       len_we,
  input  logic [$clog2(BYTES):0]     len_wdata,
  input  logic                       start,
  output logic                       busy,
  output logic                       done,
  output logic                       spi_cs_n,
  output logic                       spi_sclk,
  output logic                       spi_mosi,
  input  logic                       spi_miso
);
  localparam int IW = $clog2(BYTES);
  localparam int LW = IW + 1;
  localparam int BW = IW + 3;
  localparam int CW = $clog2(HALF + 1);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_HOLD} st_t;

  st_t                st;
  logic [8*BYTES-1:0] bmem;
  logic [LW-1:0]      len_r, len_eff;
  logic [BW-1:0]      bit_n;
  logic [IW-1:0]      last_byte;
  logic [CW-1:0]      cnt;
  logic               tick, miso_unused;

  assign miso_unused = spi_miso;
  assign len_eff     = (len_r > LW'(BYTES)) ? LW'(BYTES) : len_r;
  assign tick        = (cnt == CW'(HALF - 1));
  assign busy        = (st != S_IDLE);
  assign spi_mosi    = (st == S_RUN) && bmem[{bit_n[BW-1:3], ~bit_n[2:0]}];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      bmem  <= '0;
      len_r <= '0;
    end else if (!busy) begin
      if (buf_we) bmem[buf_idx*8 +: 8] <= buf_wdata;
      if (len_we) len_r <= len_wdata;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      spi_sclk  <= 1'b0;
      spi_cs_n  <= 1'b1;
      done      <= 1'b0;
      bit_n     <= '0;
      last_byte <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE:
          if (start) begin
            if (len_eff == '0) done <= 1'b1;
            else begin
              st        <= S_RUN;
              spi_cs_n  <= 1'b0;
              cnt       <= '0;
              bit_n     <= '0;
              last_byte <= IW'(len_eff - LW'(1));
            end
          end
        S_RUN:
          if (tick) begin
            cnt <= '0;
            if (!spi_sclk) spi_sclk <= 1'b1;
            else begin
              spi_sclk <= 1'b0;
              if (bit_n == {last_byte, 3'b111}) st <= S_HOLD;
              else bit_n <= bit_n + BW'(1);
            end
          end else cnt <= cnt + CW'(1);
        default:
          if (tick) begin
            cnt      <= '0;
            spi_cs_n <= 1'b1;
            done     <= 1'b1;
            st       <= S_IDLE;
          end else cnt <= cnt + CW'(1);
      endcase
    end

  AST_IDLE_CLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !spi_sclk); // R4
  AST_MOSI_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_sclk && $past(spi_sclk)) |-> $stable(spi_mosi)); // R4
  AST_EDGE_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_sclk) |-> !spi_cs_n); // R5
  AST_RELEASE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_cs_n) |-> (done && !busy)); // R6
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R6
  AST_BUF_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(bmem) && $stable(len_r))); // R7
  AST_ZERO_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && len_eff == '0) |=> (done && spi_cs_n)); // R8
endmodule

// File: tb/sim_spi_cmd_master.sv
module sim_spi_cmd_master;
  localparam int HALF = 2;
  logic clk = 0, rst_n = 0;
  logic buf_we = 0, len_we = 0, start = 0, spi_miso = 0;
  logic [2:0] buf_idx = 0;
  logic [7:0] buf_wdata = 0;
  logic [3:0] len_wdata = 0;
  logic busy, done, spi_cs_n, spi_sclk, spi_mosi;

  spi_cmd_master #(.HALF(HALF), .BYTES(8)) u0 (
    .clk(clk), .rst_n(rst_n), .buf_we(buf_we), .buf_idx(buf_idx),
    .buf_wdata(buf_wdata), .len_we(len_we), .len_wdata(len_wdata),
    .start(start), .busy(busy), .done(done), .spi_cs_n(spi_cs_n),
    .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso));

  always #2 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0, last_rise = 0;
  int nrise, setup_n, hold_n, per_err, cs_err, mosi_err, done_err, cs_falls;
  logic [63:0] cap;
  logic sclk_p = 0, mosi_p = 0, done_p = 0, cs_p = 1;
  logic [15:0] lfsr = 16'hACE1;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clr_mon();
    nrise = 0; setup_n = 0; hold_n = 0; per_err = 0; cs_err = 0;
    mosi_err = 0; done_err = 0; cs_falls = 0; cap = '0;
  endtask

  always @(negedge clk) begin
    cyc++;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    spi_miso = lfsr[0];
    if (spi_sclk && !sclk_p) begin
      if (nrise > 0 && cyc - last_rise != 2*HALF) per_err++;
      if (spi_cs_n) cs_err++;
      last_rise = cyc;
      cap = {cap[62:0], spi_mosi};
      nrise++;
    end
    if (spi_sclk && sclk_p && spi_mosi != mosi_p) mosi_err++;
    if (!spi_cs_n && nrise == 0 && !spi_sclk) setup_n++;
    if (!spi_sclk && sclk_p) hold_n = 1;
    else if (!spi_cs_n && !spi_sclk && nrise > 0) hold_n++;
    if (!busy && spi_sclk) cs_err++;
    if (done && done_p) done_err++;
    if (!spi_cs_n && cs_p) cs_falls++;
    sclk_p = spi_sclk; mosi_p = spi_mosi; done_p = done; cs_p = spi_cs_n;
  end

  task automatic load(input logic [63:0] b, input logic [3:0] len);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); buf_we = 1; buf_idx = 3'(i); buf_wdata = b[63-8*i -: 8];
    end
    @(negedge clk); buf_we = 0; len_we = 1; len_wdata = len;
    @(negedge clk); len_we = 0;
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic wait_done(input string req);
    int t = 0;
    while (!done && t < 3000) begin @(negedge clk); t++; end
    chk(done, req, 0, 1);
  endtask

  task automatic run_xfer(input string req, input logic [63:0] b, input logic [3:0] len);
    int k = (len > 8) ? 8 : int'(len);
    logic [63:0] exp = b >> (8*(8-k));
    clr_mon();
    pulse_start();
    chk(busy && !spi_cs_n, {req, "/R6 busy after start"}, busy, 1);
    wait_done(req);
    chk(spi_cs_n && !busy, {req, "/R6 cs released with done"}, spi_cs_n, 1);
    @(negedge clk);
    chk(!done && done_err == 0, {req, "/R6 done one cycle"}, done, 0);
    chk(nrise == 8*k, {req, " edge count"}, nrise, 8*k);
    chk(cap == exp, {req, " bit stream"}, cap, exp);
    chk(setup_n >= HALF && hold_n >= HALF, {req, "/R5 setup hold"}, setup_n*100+hold_n, HALF*101);
    chk(per_err == 0 && cs_err == 0, {req, "/R5 clock period and frame"}, per_err+cs_err, 0);
    chk(mosi_err == 0, {req, "/R4 mosi stable while sclk high"}, mosi_err, 0);
  endtask

  task automatic t_reset();
    chk(spi_cs_n && !spi_sclk && !busy && !done, "R1 reset state",
        {spi_cs_n, spi_sclk, busy, done}, 4'b1000);
  endtask

  task automatic t_erase();
    load(64'h20_12_34_56_00000000, 4); run_xfer("R2 sector erase", 64'h20_12_34_56_00000000, 4);
    load(64'h52_0A_80_00_FFFFFFFF, 4); run_xfer("R2 32K erase",   64'h52_0A_80_00_FFFFFFFF, 4);
    load(64'hD8_FF_00_01_55555555, 4); run_xfer("R2 64K erase",   64'hD8_FF_00_01_55555555, 4);
  endtask

  task automatic t_program();
    load(64'h02_00_FE_DB_BF_000000, 5); run_xfer("R3 byte program R9", 64'h02_00_FE_DB_BF_000000, 5);
  endtask

  task automatic t_zero_len();
    load(64'hD8_11_22_33_44556677, 0);
    clr_mon();
    pulse_start();
    chk(done && spi_cs_n && !busy, "R8 done next cycle", done, 1);
    @(negedge clk);
    chk(!done, "R8 done single", done, 0);
    repeat (10) @(negedge clk);
    chk(cs_falls == 0 && nrise == 0, "R8 no chip select", cs_falls + nrise, 0);
  endtask

  task automatic t_lengths();
    load(64'hA5_00000000000000, 1); run_xfer("R10 len 1", 64'hA5_00000000000000, 1);
    load(64'h0123456789ABCDEF, 8); run_xfer("R10 len 8", 64'h0123456789ABCDEF, 8);
    load(64'hFEDCBA9876543210, 12); run_xfer("R10 len 12 clamps", 64'hFEDCBA9876543210, 12);
  endtask

  task automatic t_busy_ignore();
    logic [63:0] b = 64'h20_C3_3C_81_00000000;
    int k;
    load(b, 4);
    clr_mon();
    pulse_start();
    repeat (5) @(negedge clk);
    buf_we = 1; buf_idx = 0; buf_wdata = 8'hAA; len_we = 1; len_wdata = 1; start = 1;
    @(negedge clk); buf_we = 0; len_we = 0; start = 0;
    wait_done("R7 first");
    @(negedge clk);
    chk(nrise == 32 && cap == 64'h20C33C81, "R7 stream unchanged", cap, 64'h20C33C81);
    k = 0;
    repeat (20) begin @(negedge clk); if (!spi_cs_n) k++; end
    chk(k == 0, "R7 start during busy dropped", k, 0);
    run_xfer("R7 buffer kept", b, 4);
  endtask

  initial begin
    clr_mon();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_erase();
    t_program();
    t_zero_len();
    t_lengths();
    t_busy_ignore();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule